// File: doc/BRIEF.md
# Parallel translated cache-tag hit logic

This block decides whether a load or store hits in a physically tagged, set-associative data cache that is addressed through a set-associative TLB. The TLB words and the cache tag words of the selected sets are read elsewhere and are presented here together with the page part of the effective address. The block finds which TLB way matches the effective page and produces the cache hit result. It also reports whether the access must bypass the cache and whether translation missed.

The translated path avoids putting three steps in a row: the effective-page match, the selection of a real page number and the tag compare. Each real page number held by a TLB way is compared against each cache way's tag at once, in a grid of TLB ways by cache ways. The row of that grid that belongs to the matching TLB way becomes the cache hit vector. When translation is disabled, the effective address is used as the real address and is compared with the cache tags directly. In that mode, addresses whose low word has 0xC in its top nibble are treated as uncached I/O.

All outputs are combinational functions of the inputs. Cache ways and TLB ways are picked by lowest index when several match.

Top module: `pxtag_hit`

## Requirements
- R1: With `xlate_en`=1 and TLB way t matching (`tlb_valid[t]`=1 and its virtual tag equal to `ea_page[EPN_W-1:TSET_BITS]`), cache way c is a hit candidate exactly when `cache_valid[c]`=1 and its tag equals bits `[RPN_W-1:TAG_LSB-PG_BITS]` of way t's real page number.
- R2: With `xlate_en`=1 and no TLB way matching, `tlb_miss`=1, `hit`=0 and `hit_vec` is all zeros, whatever the cache tags hold.
- R3: When several TLB ways match, the lowest-numbered matching TLB way supplies the real page number.
- R4: With `xlate_en`=0, cache way c is a hit candidate exactly when `cache_valid[c]`=1 and its tag equals `ea_page[RA_W-PG_BITS-1:TAG_LSB-PG_BITS]`; the TLB inputs have no effect and `tlb_miss`=0.
- R5: With `xlate_en`=0 and effective address bits 31..28 (bits `31-PG_BITS` to `28-PG_BITS` of `ea_page`) equal to 4'hC, `inhibit`=1 and `hit`=0 and `hit_vec` is all zeros even when a tag matches.
- R6: With `xlate_en`=1, `inhibit`=0 for every address, including those with 4'hC in address bits 31..28.
- R7: A cache way whose valid bit is 0 never appears in `hit_vec`, even when its tag matches.
- R8: When several cache ways are candidates, only the lowest-numbered one is set in `hit_vec`; `hit_vec` never has more than one bit set.
- R9: `hit` is 1 exactly when `hit_vec` is nonzero, and `hit_way` is the binary index of the set bit of `hit_vec`, or 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xlate_en | input | 1 | 1: translate through the TLB; 0: real mode |
| ea_page | input | EA_W-PG_BITS | Effective address above the page offset |
| tlb_valid | input | TLB_WAYS | Valid bit of each TLB way in the indexed set |
| tlb_vtag | input | TLB_WAYS*VTAG_W | Virtual tag of each TLB way, way 0 in the low bits |
| tlb_rpn | input | TLB_WAYS*RPN_W | Real page number of each TLB way, way 0 in the low bits |
| cache_valid | input | CACHE_WAYS | Valid bit of each cache way in the indexed set |
| cache_tag | input | CACHE_WAYS*TAG_W | Stored tag of each cache way, way 0 in the low bits |
| hit_vec | output | CACHE_WAYS | One-hot cache way that hit |
| hit_way | output | max(1,clog2(CACHE_WAYS)) | Binary index of the hitting way |
| hit | output | 1 | Any cache way hit |
| inhibit | output | 1 | Real-mode I/O access, cache bypassed |
| tlb_miss | output | 1 | Translation enabled and no TLB way matched |

## Verification
The bench sets up two matching TLB ways with different real page numbers and tags that agree with only one of them. A design that took the wrong row of the comparator grid, or the highest matching way, would then report a different way. It plants the ea tag into the cache while translation misses, and uses 0xC addresses in both modes. A design that leaked the real-mode compare into translated accesses, or applied the I/O rule to translated ones, would report a hit or an inhibit where none belongs. Duplicate and invalid matching cache tags catch a broken priority pick or ignored valid bits, which show up as a multi-hot vector, a wrong `hit_way` or a hit on a dead line. Random vectors built from the TLB and address fields keep the near-miss mixes dense.

// File: rtl/pxtag_pkg.sv
package pxtag_pkg;

   // Index width for a one-of-n selection; never zero.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic {
      MODE_REAL  = 1'b0,
      MODE_XLATE = 1'b1
   } xmode_e;

   // Address nibble that marks an uncached real-mode access.
   localparam logic [3:0] IO_NIBBLE = 4'hC;

endpackage

// File: rtl/pxtag_pick.sv
module pxtag_pick
   import pxtag_pkg::*;
#(
   parameter int W = 2
) (
   input  logic [W-1:0]           req,
   output logic [W-1:0]           onehot,
   output logic [idx_w(W)-1:0]    idx,
   output logic                   any
);

   localparam int IW = idx_w(W);

   generate
      if (W < 1) begin : g_bad_w
         $error("pxtag_pick: W must be at least 1");
      end
   endgenerate

   // Lowest set request wins: scan from the top so the last write stands.
   always_comb begin
      onehot = '0;
      idx    = '0;
      any    = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IW'(i);
            any       = 1'b1;
         end
      end
   end

   always_comb begin
      // R8
      pick_onehot_chk : assert ($onehot0(onehot))
         else $error("pick produced a multi-hot vector");
      // R8
      pick_covers_req_chk : assert ((onehot & ~req) == '0)
         else $error("pick selected an unrequested bit");
   end

endmodule

// File: rtl/pxtag_tlbcmp.sv
module pxtag_tlbcmp #(
   parameter int TLB_WAYS = 2,
   parameter int VTAG_W   = 46
) (
   input  logic [VTAG_W-1:0]          va_tag,
   input  logic [TLB_WAYS-1:0]        tlb_valid,
   input  logic [TLB_WAYS*VTAG_W-1:0] tlb_vtag,
   output logic [TLB_WAYS-1:0]        way_match
);

   generate
      if (TLB_WAYS < 1 || VTAG_W < 1) begin : g_bad_cfg
         $error("pxtag_tlbcmp: TLB_WAYS and VTAG_W must be positive");
      end
      for (genvar t = 0; t < TLB_WAYS; t++) begin : g_way
         assign way_match[t] = tlb_valid[t] &&
                               (tlb_vtag[t*VTAG_W +: VTAG_W] == va_tag);
      end
   endgenerate

   always_comb begin
      // R1
      tlb_valid_gate_chk : assert ((way_match & ~tlb_valid) == '0)
         else $error("invalid TLB way reported a match");
   end

endmodule

// File: rtl/pxtag_xcmp.sv
module pxtag_xcmp #(
   parameter int TLB_WAYS   = 2,
   parameter int CACHE_WAYS = 2,
   parameter int TAG_W      = 44
) (
   input  logic [TLB_WAYS*TAG_W-1:0]      xtag,
   input  logic [CACHE_WAYS*TAG_W-1:0]    ctag,
   output logic [TLB_WAYS*CACHE_WAYS-1:0] grid
);

   generate
      if (TLB_WAYS < 1 || CACHE_WAYS < 1 || TAG_W < 1) begin : g_bad_cfg
         $error("pxtag_xcmp: all dimensions must be positive");
      end
      // One comparator per (TLB way, cache way) pair; row t holds TLB way t.
      for (genvar t = 0; t < TLB_WAYS; t++) begin : g_row
         for (genvar c = 0; c < CACHE_WAYS; c++) begin : g_col
            assign grid[t*CACHE_WAYS + c] =
               (xtag[t*TAG_W +: TAG_W] == ctag[c*TAG_W +: TAG_W]);
         end
      end
   endgenerate

endmodule

// File: rtl/pxtag_rcmp.sv
module pxtag_rcmp #(
   parameter int CACHE_WAYS = 2,
   parameter int TAG_W      = 44
) (
   input  logic [TAG_W-1:0]            rtag,
   input  logic [CACHE_WAYS*TAG_W-1:0] ctag,
   output logic [CACHE_WAYS-1:0]       match
);

   generate
      if (CACHE_WAYS < 1 || TAG_W < 1) begin : g_bad_cfg
         $error("pxtag_rcmp: dimensions must be positive");
      end
      for (genvar c = 0; c < CACHE_WAYS; c++) begin : g_way
         assign match[c] = (ctag[c*TAG_W +: TAG_W] == rtag);
      end
   endgenerate

endmodule

// File: rtl/pxtag_hit.sv
module pxtag_hit
   import pxtag_pkg::*;
#(
   parameter int CACHE_WAYS = 2,
   parameter int TLB_WAYS   = 2,
   parameter int EA_W       = 64,
   parameter int RA_W       = 56,
   parameter int PG_BITS    = 12,
   parameter int TSET_BITS  = 6,
   parameter int TAG_LSB    = 12,
   localparam int EPN_W     = EA_W - PG_BITS,
   localparam int VTAG_W    = EPN_W - TSET_BITS,
   localparam int RPN_W     = RA_W - PG_BITS,
   localparam int TAG_W     = RA_W - TAG_LSB,
   localparam int WAY_W     = idx_w(CACHE_WAYS)
) (
   input  logic                           xlate_en,
   input  logic [EPN_W-1:0]               ea_page,
   input  logic [TLB_WAYS-1:0]            tlb_valid,
   input  logic [TLB_WAYS*VTAG_W-1:0]     tlb_vtag,
   input  logic [TLB_WAYS*RPN_W-1:0]      tlb_rpn,
   input  logic [CACHE_WAYS-1:0]          cache_valid,
   input  logic [CACHE_WAYS*TAG_W-1:0]    cache_tag,
   output logic [CACHE_WAYS-1:0]          hit_vec,
   output logic [WAY_W-1:0]               hit_way,
   output logic                           hit,
   output logic                           inhibit,
   output logic                           tlb_miss
);

   // Bit positions of address bits 31..28 inside ea_page.
   localparam int IO_HI  = 31 - PG_BITS;
   localparam int IO_LO  = 28 - PG_BITS;
   // Tag slices, relative to the page number.
   localparam int TAG_PLO = TAG_LSB - PG_BITS;
   localparam int RTAG_HI = RA_W - PG_BITS - 1;

   // Elaboration-time configuration checks.
   generate
      if (CACHE_WAYS < 1 || TLB_WAYS < 1) begin : g_bad_ways
         $error("pxtag_hit: way counts must be positive");
      end
      if (RA_W > EA_W) begin : g_bad_ra
         $error("pxtag_hit: RA_W must not exceed EA_W");
      end
      if (TAG_LSB < PG_BITS || TAG_LSB >= RA_W) begin : g_bad_tag
         $error("pxtag_hit: tag must lie above the page offset and below RA_W");
      end
      if (PG_BITS > 28 || EA_W < 32) begin : g_bad_io
         $error("pxtag_hit: address bits 31..28 must lie in ea_page");
      end
      if (VTAG_W < 1) begin : g_bad_vtag
         $error("pxtag_hit: TLB set index leaves no virtual tag");
      end
   endgenerate

   xmode_e mode;
   assign mode = xlate_en ? MODE_XLATE : MODE_REAL;

   // ---------------- TLB way match ----------------
   logic [TLB_WAYS-1:0] tlb_raw;
   logic [TLB_WAYS-1:0] tlb_sel;
   logic [idx_w(TLB_WAYS)-1:0] tlb_idx_unused;
   logic                tlb_any;

   pxtag_tlbcmp #(
      .TLB_WAYS (TLB_WAYS),
      .VTAG_W   (VTAG_W)
   ) u_tlbcmp (
      .va_tag    (ea_page[EPN_W-1:TSET_BITS]),
      .tlb_valid (tlb_valid),
      .tlb_vtag  (tlb_vtag),
      .way_match (tlb_raw)
   );

   pxtag_pick #(.W(TLB_WAYS)) u_tlb_pick (
      .req    (tlb_raw),
      .onehot (tlb_sel),
      .idx    (tlb_idx_unused),
      .any    (tlb_any)
   );

   // ---------------- Translated tags per TLB way ----------------
   logic [TLB_WAYS*TAG_W-1:0] xtag;

   generate
      for (genvar t = 0; t < TLB_WAYS; t++) begin : g_xtag
         if (TAG_PLO == 0) begin : g_full
            assign xtag[t*TAG_W +: TAG_W] = tlb_rpn[t*RPN_W +: RPN_W];
         end else begin : g_upper
            logic [RPN_W-1:0] rpn_t;
            assign rpn_t = tlb_rpn[t*RPN_W +: RPN_W];
            assign xtag[t*TAG_W +: TAG_W] = rpn_t[RPN_W-1:TAG_PLO];
         end
      end
   endgenerate

   // ---------------- Comparator grid and real-mode compare ----------------
   logic [TLB_WAYS*CACHE_WAYS-1:0] grid;
   logic [CACHE_WAYS-1:0]          rmatch;

   pxtag_xcmp #(
      .TLB_WAYS   (TLB_WAYS),
      .CACHE_WAYS (CACHE_WAYS),
      .TAG_W      (TAG_W)
   ) u_xcmp (
      .xtag (xtag),
      .ctag (cache_tag),
      .grid (grid)
   );

   pxtag_rcmp #(
      .CACHE_WAYS (CACHE_WAYS),
      .TAG_W      (TAG_W)
   ) u_rcmp (
      .rtag  (ea_page[RTAG_HI:TAG_PLO]),
      .ctag  (cache_tag),
      .match (rmatch)
   );

   // ---------------- Row select on the TLB hit way ----------------
   logic [CACHE_WAYS-1:0] xrow;

   always_comb begin
      xrow = '0;
      for (int t = 0; t < TLB_WAYS; t++) begin
         if (tlb_sel[t]) begin
            xrow = xrow | grid[t*CACHE_WAYS +: CACHE_WAYS];
         end
      end
   end

   // ---------------- Mode merge, qualification, final pick ----------------
   logic [CACHE_WAYS-1:0] cand;
   logic [CACHE_WAYS-1:0] qual;

   assign inhibit  = (mode == MODE_REAL) && (ea_page[IO_HI:IO_LO] == IO_NIBBLE);
   assign tlb_miss = (mode == MODE_XLATE) && !tlb_any;
   assign cand     = (mode == MODE_XLATE) ? xrow : rmatch;
   assign qual     = cand & cache_valid & {CACHE_WAYS{!inhibit}};

   pxtag_pick #(.W(CACHE_WAYS)) u_way_pick (
      .req    (qual),
      .onehot (hit_vec),
      .idx    (hit_way),
      .any    (hit)
   );

   always_comb begin
      // R2
      miss_no_hit_chk : assert (!(tlb_miss && (hit_vec != '0)))
         else $error("cache hit reported on a TLB miss");
      // R4
      real_no_miss_chk : assert (!(tlb_miss && !xlate_en))
         else $error("TLB miss reported in real mode");
      // R5
      inhibit_no_hit_chk : assert (!(inhibit && hit))
         else $error("hit reported on an inhibited access");
      // R6
      inhibit_real_only_chk : assert (!(inhibit && xlate_en))
         else $error("inhibit raised on a translated access");
      // R7
      valid_hit_chk : assert ((hit_vec & ~cache_valid) == '0)
         else $error("hit on an invalid cache way");
      // R8
      onehot_hit_chk : assert ($onehot0(hit_vec))
         else $error("hit vector has several bits set");
      // R9
      hit_flag_chk : assert (hit == (hit_vec != '0))
         else $error("hit flag disagrees with hit vector");
      // R9
      way_index_chk : assert (!hit || hit_vec[hit_way])
         else $error("hit_way does not point at the hit bit");
   end

endmodule

// File: tb/pxtag_hit_test.sv
module pxtag_hit_test;

   localparam int CW   = 4;
   localparam int TW   = 2;
   localparam int EAW  = 64;
   localparam int RAW  = 56;
   localparam int PG   = 12;
   localparam int TS   = 6;
   localparam int TL   = 12;
   localparam int EPN  = EAW - PG;
   localparam int VT   = EPN - TS;
   localparam int RPN  = RAW - PG;
   localparam int TG   = RAW - TL;
   localparam int WW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // Bench-side stimulus state
   logic            b_x;
   logic [EPN-1:0]  b_epn;
   logic [TW-1:0]   b_tv;
   logic [VT-1:0]   b_vt  [TW];
   logic [RPN-1:0]  b_rpn [TW];
   logic [CW-1:0]   b_cv;
   logic [TG-1:0]   b_ct  [CW];

   logic [TW*VT-1:0]  tlb_vtag;
   logic [TW*RPN-1:0] tlb_rpn;
   logic [CW*TG-1:0]  cache_tag;

   always_comb begin
      for (int t = 0; t < TW; t++) begin
         tlb_vtag[t*VT +: VT]   = b_vt[t];
         tlb_rpn[t*RPN +: RPN]  = b_rpn[t];
      end
      for (int c = 0; c < CW; c++) begin
         cache_tag[c*TG +: TG] = b_ct[c];
      end
   end

   logic [CW-1:0] hit_vec;
   logic [WW-1:0] hit_way;
   logic          hit, inhibit, tlb_miss;

   pxtag_hit #(
      .CACHE_WAYS (CW), .TLB_WAYS (TW), .EA_W (EAW), .RA_W (RAW),
      .PG_BITS (PG), .TSET_BITS (TS), .TAG_LSB (TL)
   ) uut (
      .xlate_en    (b_x),
      .ea_page     (b_epn),
      .tlb_valid   (b_tv),
      .tlb_vtag    (tlb_vtag),
      .tlb_rpn     (tlb_rpn),
      .cache_valid (b_cv),
      .cache_tag   (cache_tag),
      .hit_vec     (hit_vec),
      .hit_way     (hit_way),
      .hit         (hit),
      .inhibit     (inhibit),
      .tlb_miss    (tlb_miss)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // Reference model written from the requirements.
   task automatic model(output logic [CW-1:0] ev, output logic [WW-1:0] ew,
                        output logic eh, output logic ei, output logic em);
      int sel = -1;
      logic [TG-1:0] want;
      for (int t = 0; t < TW; t++)
         if (sel < 0 && b_tv[t] && b_vt[t] == b_epn[EPN-1:TS]) sel = t;
      ei = !b_x && (b_epn[31-PG:28-PG] == 4'hC);
      em = b_x && (sel < 0);
      if (b_x) want = (sel >= 0) ? b_rpn[sel][RPN-1:TL-PG] : '0;
      else     want = b_epn[RAW-PG-1:TL-PG];
      ev = '0; ew = '0; eh = 1'b0;
      if (!ei && !em)
         for (int c = 0; c < CW; c++)
            if (!eh && b_cv[c] && b_ct[c] == want) begin
               ev[c] = 1'b1; ew = WW'(c); eh = 1'b1;
            end
   endtask

   task automatic check(input string tag);
      logic [CW-1:0] ev; logic [WW-1:0] ew; logic eh, ei, em;
      @(posedge clk); #1;
      model(ev, ew, eh, ei, em);
      n_chk++;
      if (hit_vec !== ev || hit_way !== ew || hit !== eh ||
          inhibit !== ei || tlb_miss !== em) begin
         n_fail++;
         $display("FAIL %s: got vec=%b way=%0d hit=%b inh=%b miss=%b, expected vec=%b way=%0d hit=%b inh=%b miss=%b",
                  tag, hit_vec, hit_way, hit, inhibit, tlb_miss, ev, ew, eh, ei, em);
      end
   endtask

   task automatic clear();
      @(negedge clk);
      b_x = 1'b0; b_epn = '0; b_tv = '0; b_cv = '0;
      for (int t = 0; t < TW; t++) begin b_vt[t] = '0; b_rpn[t] = '0; end
      for (int c = 0; c < CW; c++) b_ct[c] = '0;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   // A safe base address whose bits 31..28 are not 0xC.
   task automatic base_addr();
      b_epn = EPN'(rnd64());
      b_epn[31-PG:28-PG] = 4'h3;
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      clear();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R9 quiet state: nothing valid, real mode, address zero
      check("R9 idle");

      // R1 translated hit through TLB way 1 into cache way 2
      clear(); base_addr(); b_x = 1'b1;
      b_tv = 2'b10; b_vt[1] = b_epn[EPN-1:TS]; b_rpn[1] = RPN'(rnd64());
      b_vt[0] = b_epn[EPN-1:TS]; b_rpn[0] = RPN'(rnd64());
      b_cv = 4'b1111; b_ct[2] = b_rpn[1]; b_ct[0] = b_rpn[0];
      b_ct[1] = TG'(rnd64()); b_ct[3] = b_epn[RAW-PG-1:0];
      check("R1 xlate hit way2");

      // R3 both TLB ways match, way 0 must supply the page
      clear(); base_addr(); b_x = 1'b1;
      b_tv = 2'b11; b_vt[0] = b_epn[EPN-1:TS]; b_vt[1] = b_epn[EPN-1:TS];
      b_rpn[0] = RPN'(rnd64()); b_rpn[1] = ~b_rpn[0];
      b_cv = 4'b1111; b_ct[1] = b_rpn[1]; b_ct[3] = b_rpn[0];
      b_ct[0] = TG'(rnd64()); b_ct[2] = TG'(rnd64());
      check("R3 tlb priority");

      // R2 TLB miss with cache holding the untranslated tag
      clear(); base_addr(); b_x = 1'b1;
      b_tv = 2'b01; b_vt[0] = ~b_epn[EPN-1:TS]; b_rpn[0] = b_epn[RAW-PG-1:0];
      b_vt[1] = b_epn[EPN-1:TS];
      b_cv = 4'b1111;
      for (int c = 0; c < CW; c++) b_ct[c] = b_epn[RAW-PG-1:0];
      check("R2 tlb miss");

      // R4 real mode, TLB holds conflicting data
      clear(); base_addr(); b_x = 1'b0;
      b_tv = 2'b11; b_vt[0] = b_epn[EPN-1:TS]; b_vt[1] = b_epn[EPN-1:TS];
      b_rpn[0] = RPN'(rnd64()); b_rpn[1] = RPN'(rnd64());
      b_cv = 4'b1111; b_ct[0] = b_epn[RAW-PG-1:0];
      b_ct[1] = b_rpn[0]; b_ct[2] = b_rpn[1]; b_ct[3] = TG'(rnd64());
      check("R4 real hit way0");

      // R5 real-mode 0xC address with matching tag
      clear(); base_addr(); b_x = 1'b0;
      b_epn[31-PG:28-PG] = 4'hC;
      b_cv = 4'b1111; b_ct[1] = b_epn[RAW-PG-1:0];
      check("R5 inhibit");

      // R6 translated 0xC address that hits
      clear(); base_addr(); b_x = 1'b1;
      b_epn[31-PG:28-PG] = 4'hC;
      b_tv = 2'b01; b_vt[0] = b_epn[EPN-1:TS]; b_rpn[0] = RPN'(rnd64());
      b_cv = 4'b1111; b_ct[3] = b_rpn[0];
      check("R6 no inhibit in xlate");

      // R7 matching way invalid, a later valid way also matches
      clear(); base_addr(); b_x = 1'b0;
      b_cv = 4'b0110; b_ct[0] = b_epn[RAW-PG-1:0]; b_ct[2] = b_epn[RAW-PG-1:0];
      check("R7 invalid skipped");

      // R7 only match is invalid
      clear(); base_addr(); b_x = 1'b0;
      b_cv = 4'b1110; b_ct[0] = b_epn[RAW-PG-1:0];
      check("R7 invalid no hit");

      // R8 duplicate tags in ways 1 and 3
      clear(); base_addr(); b_x = 1'b1;
      b_tv = 2'b10; b_vt[1] = b_epn[EPN-1:TS]; b_rpn[1] = RPN'(rnd64());
      b_cv = 4'b1111; b_ct[1] = b_rpn[1]; b_ct[3] = b_rpn[1];
      check("R8 duplicate tags");

      // R9 hit in the top way gives index 3
      clear(); base_addr(); b_x = 1'b0;
      b_cv = 4'b1000; b_ct[3] = b_epn[RAW-PG-1:0];
      check("R9 top way index");

      // Random mix across R1 R2 R3 R4 R5 R6 R7 R8
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         b_x = ($urandom() % 4) != 0;
         b_epn = EPN'(rnd64());
         if (($urandom() % 4) == 0) b_epn[31-PG:28-PG] = 4'hC;
         for (int t = 0; t < TW; t++) begin
            b_tv[t]  = ($urandom() % 4) != 0;
            b_vt[t]  = ($urandom() % 2) ? b_epn[EPN-1:TS] : VT'(rnd64());
            b_rpn[t] = ($urandom() % 8 == 0) ? b_rpn[0] : RPN'(rnd64());
         end
         for (int c = 0; c < CW; c++) begin
            b_cv[c] = ($urandom() % 5) != 0;
            case ($urandom() % 4)
               0: b_ct[c] = b_rpn[0];
               1: b_ct[c] = b_rpn[1];
               2: b_ct[c] = b_epn[RAW-PG-1:0];
               default: b_ct[c] = TG'(rnd64());
            endcase
         end
         check("R1-mix random");
      end

      summary();
      $finish;
   end

endmodule